// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects eight interrupt request lines, filters them through a programmable mask and forwards the most urgent one to a processor on a single interrupt line. When the processor acknowledges, the controller returns an 8-bit vector number that identifies the level. It then records that level as being serviced until software declares the service finished. Requests of equal or lower priority wait while a level is in service. A request of higher priority can still interrupt, so handlers nest.

Software configures the block through a small synchronous write port. Through it, software sets the mask, the vector base, the operating mode and the trigger style of each line, and issues end-of-service commands. The end of service can name a level explicitly, can target the most urgent level in service, or can happen automatically at acknowledge. Priority is either fixed, with level 0 most urgent, or rotating, so that a level that has just been served drops to the back of the queue.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the controller clears all of the following: the request, service and mask state, the vector output, the trigger selection (all edge), the mode (fixed priority, manual end of service) and the vector base. `int_out` is low after reset.
- R2: An edge-selected line sets its request bit on a rising transition after two synchronizer stages. A rise driven before clock edge k is visible on `int_out` after edge k+2 and not after edge k+1. The request stays set after the line falls, until the level is acknowledged.
- R3: A level-selected line (trigger register bit = 1) has its request bit follow the synchronized input on every cycle. The request drops when the line falls, and it raises `int_out` again after an end of service if the line is still high.
- R4: A level whose mask bit is 1 never raises `int_out` and is never acknowledged. Its request is still recorded, and clearing the mask bit forwards it on the next cycle.
- R5: In fixed priority, level 0 is the most urgent and level 7 the least. With several requests pending, the lowest-numbered unmasked level is acknowledged first.
- R6: `int_out` is high exactly when some unmasked request exists whose priority is strictly higher than that of every level in service.
- R7: When `ack` is high on an edge while `int_out` is high, the controller takes the selected level. The `vec_out` output shows `{base[7:3], level}` from the next cycle on. The level moves from request to in-service on that edge. When `ack` is high while `int_out` is low, the edge has no effect and `vec_out` keeps its value.
- R8: A write to address 4 with data bit 3 = 1 is a specific end of service for the level in data bits 2:0. It clears only that in-service bit.
- R9: A write to address 4 with data bit 3 = 0 clears the in-service bit of the most urgent level currently in service.
- R10: With mode bit 0 = 1 (automatic end of service), an acknowledge does not set an in-service bit, so a lower-priority request is forwarded right after.
- R11: With mode bit 1 = 1 (rotating priority), a level becomes the least urgent whenever its in-service bit is cleared or it is taken under automatic end of service. The next level up becomes the most urgent.
- R12: The write port uses these addresses: 0 sets the mask, 1 sets the vector base (only bits 7:3 are kept), 2 sets the mode and 3 sets the trigger selection. A write takes effect on the edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous request lines, one per level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ack | input | 1 | Processor acknowledge, one cycle per acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the most recently acknowledged level |

## Verification
The assertions assume that software never issues an end-of-service command on the same edge as a taken acknowledge. They also assume that `ack` is a single-cycle pulse. The bench keeps to both: every write and acknowledge goes through its own task, separated by at least one idle cycle. Request lines change only on falling clock edges. An edge-selected line is held high for three cycles before it is released, so every rise is captured. A behavioural model runs alongside the bench and compares both outputs on every cycle. Directed checks cover nesting, masking, both trigger styles, all three end-of-service styles and rotation.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_LVL  = 8;
    localparam int LVL_W    = $clog2(NUM_LVL);
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int BASE_W   = DATA_W - LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK = 3'd0,
        SEL_BASE = 3'd1,
        SEL_MODE = 3'd2,
        SEL_TRIG = 3'd3,
        SEL_EOI  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic rotate;
        logic auto_eoi;
    } mode_t;

    typedef struct packed {
        logic valid;
        logic specific;
        lvl_t lvl;
    } eoi_cmd_t;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } pick_t;

    // Lowest-priority level when rotation is off.
    function automatic lvl_t fixed_lowest();
        return lvl_t'(NUM_LVL - 1);
    endfunction

endpackage

// File: rtl/irq_prio_cfg.sv
module irq_prio_cfg
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_LVL-1:0]  mask_q,
    output logic [NUM_LVL-1:0]  trig_q,
    output logic [BASE_W-1:0]   base_hi_q,
    output mode_t               mode_q,
    output eoi_cmd_t            eoi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            trig_q    <= '0;
            base_hi_q <= '0;
            mode_q    <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_MASK: mask_q    <= wr_data[NUM_LVL-1:0];
                SEL_BASE: base_hi_q <= wr_data[DATA_W-1:LVL_W];
                SEL_MODE: mode_q    <= '{rotate: wr_data[1], auto_eoi: wr_data[0]};
                SEL_TRIG: trig_q    <= wr_data[NUM_LVL-1:0];
                default: ;
            endcase
        end
    end

    // End-of-service commands are not stored; they act on the write edge.
    always_comb begin
        eoi.valid    = wr_en && (reg_sel_e'(wr_addr) == SEL_EOI);
        eoi.specific = wr_data[LVL_W];
        eoi.lvl      = wr_data[LVL_W-1:0];
    end

endmodule

// File: rtl/irq_prio_capture.sv
module irq_prio_capture
    import irq_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic [NUM_LVL-1:0] trig_lvl,
    input  logic               take,
    input  lvl_t               take_lvl,
    output logic [NUM_LVL-1:0] req_q
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_LVL-1:0] sync_q [SYNC_STAGES];
    logic [NUM_LVL-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= irq_in;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            prev_q <= sync_q[LAST];
        end
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[g] <= 1'b0;
            end else if (trig_lvl[g]) begin
                req_q[g] <= sync_q[LAST][g];
            end else if (sync_q[LAST][g] && !prev_q[g]) begin
                req_q[g] <= 1'b1;
            end else if (take && (take_lvl == lvl_t'(g))) begin
                req_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_pkg::*;
(
    input  logic [NUM_LVL-1:0] bits,
    input  lvl_t               lowest,
    output pick_t              best,
    output lvl_t               best_rank
);

    // Scan from least to most urgent so the most urgent set bit wins.
    always_comb begin
        lvl_t cand;
        best      = '0;
        best_rank = '0;
        cand      = '0;
        for (int k = NUM_LVL - 1; k >= 0; k--) begin
            cand = lowest + lvl_t'(k) + lvl_t'(1);
            if (bits[cand]) begin
                best.valid = 1'b1;
                best.lvl   = cand;
                best_rank  = lvl_t'(k);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ack,
    output logic               int_out,
    output logic [DATA_W-1:0]  vec_out
);

    logic [NUM_LVL-1:0] mask_q;
    logic [NUM_LVL-1:0] trig_q;
    logic [BASE_W-1:0]  base_hi_q;
    mode_t              mode_q;
    eoi_cmd_t           eoi;

    logic [NUM_LVL-1:0] req_q;
    logic [NUM_LVL-1:0] isr_q;
    logic [NUM_LVL-1:0] isr_d;
    lvl_t               low_q;
    lvl_t               lowest;
    logic [DATA_W-1:0]  vec_q;

    pick_t              pick [2];
    lvl_t               rank [2];
    logic [NUM_LVL-1:0] scan [2];

    logic               take;
    logic               eoi_hit;
    lvl_t               eoi_lvl;

    irq_prio_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mask_q    (mask_q),
        .trig_q    (trig_q),
        .base_hi_q (base_hi_q),
        .mode_q    (mode_q),
        .eoi       (eoi)
    );

    irq_prio_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .trig_lvl (trig_q),
        .take     (take),
        .take_lvl (pick[0].lvl),
        .req_q    (req_q)
    );

    assign lowest  = mode_q.rotate ? low_q : fixed_lowest();
    assign scan[0] = req_q & ~mask_q;
    assign scan[1] = isr_q;

    // Picker 0 ranks forwardable requests, picker 1 ranks in-service levels.
    for (genvar p = 0; p < 2; p++) begin : g_pick
        irq_prio_pick u_pick (
            .bits      (scan[p]),
            .lowest    (lowest),
            .best      (pick[p]),
            .best_rank (rank[p])
        );
    end

    assign int_out = pick[0].valid && (!pick[1].valid || (rank[0] < rank[1]));
    assign take    = ack && int_out;

    always_comb begin
        eoi_lvl = eoi.specific ? eoi.lvl : pick[1].lvl;
        eoi_hit = eoi.valid && isr_q[eoi_lvl];
        isr_d   = isr_q;
        if (eoi_hit) isr_d[eoi_lvl] = 1'b0;
        if (take && !mode_q.auto_eoi) isr_d[pick[0].lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            low_q <= fixed_lowest();
            vec_q <= '0;
        end else begin
            isr_q <= isr_d;
            if (take) vec_q <= {base_hi_q, pick[0].lvl};
            if (mode_q.rotate) begin
                if (take && mode_q.auto_eoi) low_q <= pick[0].lvl;
                else if (eoi_hit)           low_q <= eoi_lvl;
            end
        end
    end

    assign vec_out = vec_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ack,
    input logic               int_out,
    input logic [DATA_W-1:0]  vec_out,
    input logic [NUM_LVL-1:0] req_q,
    input logic [NUM_LVL-1:0] isr_q,
    input logic [NUM_LVL-1:0] mask_q,
    input logic [BASE_W-1:0]  base_hi_q,
    input mode_t              mode_q,
    input eoi_cmd_t           eoi
);

    // R1: state is empty right after reset is released
    a_r1_reset_clears: assert property (@(posedge clk)
        $fell(rst) |-> (isr_q == '0 && req_q == '0 && vec_out == '0 && !int_out));

    // R4 / R6: the interrupt line needs an unmasked request behind it
    a_r4_mask_gates_int: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((req_q & ~mask_q) != '0));

    // R7: vector carries the base held when the acknowledge was taken
    a_r7_vector_base: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out) |=> (vec_out[DATA_W-1:LVL_W] == $past(base_hi_q)));

    // R7: the taken level is in service on the next cycle
    a_r7_take_to_service: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !mode_q.auto_eoi && !eoi.valid) |=> isr_q[vec_out[LVL_W-1:0]]);

    // R8: a specific end of service removes the named level
    a_r8_specific_clears: assert property (@(posedge clk) disable iff (rst)
        (eoi.valid && eoi.specific && !(ack && int_out)) |=> !isr_q[$past(eoi.lvl)]);

    // R10: automatic end of service leaves in-service state untouched
    a_r10_auto_keeps_service: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && mode_q.auto_eoi && !eoi.valid) |=> (isr_q == $past(isr_q)));

endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .int_out   (int_out),
    .vec_out   (vec_out),
    .req_q     (req_q),
    .isr_q     (isr_q),
    .mask_q    (mask_q),
    .base_hi_q (base_hi_q),
    .mode_q    (mode_q),
    .eoi       (eoi)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ack     (ack),
        .int_out (int_out),
        .vec_out (vec_out)
    );

    // ---------------- behavioural reference ----------------
    bit [7:0] m_s1, m_s2, m_prev, m_irr, m_isr, m_imr, m_trig, m_base, m_vec;
    bit       m_aeoi, m_rot;
    int       m_low = 7;

    function automatic int m_rank(int lvl);
        int lo;
        lo = m_rot ? m_low : 7;
        return (lvl - lo - 1 + 16) % 8;
    endfunction

    function automatic int m_best(bit [7:0] v);
        int b;
        b = -1;
        for (int i = 0; i < 8; i++)
            if (v[i] && (b < 0 || m_rank(i) < m_rank(b))) b = i;
        return b;
    endfunction

    function automatic bit m_int();
        int bp, bi;
        bp = m_best(m_irr & ~m_imr);
        bi = m_best(m_isr);
        if (bp < 0) return 1'b0;
        if (bi < 0) return 1'b1;
        return m_rank(bp) < m_rank(bi);
    endfunction

    always @(posedge clk) begin
        bit [7:0] n_irr, n_isr;
        int       bp, el;
        bit       tk;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_irr = 0; m_isr = 0; m_imr = 0;
            m_trig = 0; m_base = 0; m_vec = 0; m_aeoi = 0; m_rot = 0; m_low = 7;
        end else begin
            n_irr = m_irr;
            n_isr = m_isr;
            bp = m_best(m_irr & ~m_imr);
            tk = ack && m_int();
            for (int i = 0; i < 8; i++) begin
                if (m_trig[i]) n_irr[i] = m_s2[i];
                else if (m_s2[i] && !m_prev[i]) n_irr[i] = 1'b1;
                else if (tk && bp == i) n_irr[i] = 1'b0;
            end
            if (wr_en && wr_addr == 3'd4) begin
                el = wr_data[3] ? int'(wr_data[2:0]) : m_best(m_isr);
                if (el >= 0 && m_isr[el]) begin
                    n_isr[el] = 1'b0;
                    if (m_rot) m_low = el;
                end
            end
            if (tk) begin
                m_vec = {m_base[7:3], 3'(bp)};
                if (m_aeoi) begin
                    if (m_rot) m_low = bp;
                end else begin
                    n_isr[bp] = 1'b1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_imr = wr_data;
                    3'd1: m_base = {wr_data[7:3], 3'b000};
                    3'd2: begin m_aeoi = wr_data[0]; m_rot = wr_data[1]; end
                    3'd3: m_trig = wr_data;
                    default: ;
                endcase
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = irq_in;
            m_irr = n_irr;
            m_isr = n_isr;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(int_out === m_int(), "R6 per-cycle int_out vs model", int'(int_out), int'(m_int()));
            chk(vec_out === m_vec, "R7 per-cycle vec_out vs model", int'(vec_out), int'(m_vec));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic raise(input logic [7:0] m);
        @(negedge clk);
        irq_in = irq_in | m;
        tick(3);
        irq_in = irq_in & ~m;
    endtask

    task automatic exp_int(input bit e, input string req);
        chk(int_out === e, req, int'(int_out), int'(e));
    endtask

    task automatic exp_vec(input logic [7:0] e, input string req);
        chk(vec_out === e, req, int'(vec_out), int'(e));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        exp_int(1'b0, "R1 int_out in reset");
        exp_vec(8'h00, "R1 vec_out in reset");
        rst = 1'b0;
        tick(1);
        exp_int(1'b0, "R1 int_out after reset");

        wr(3'd1, 8'h20);                      // R12 base
        // R2 edge latency and hold
        @(negedge clk);
        irq_in[3] = 1'b1;
        tick(2);
        exp_int(1'b0, "R2 not yet after two edges");
        tick(1);
        exp_int(1'b1, "R2 request after three edges");
        irq_in[3] = 1'b0;
        tick(4);
        exp_int(1'b1, "R2 edge request held after fall");
        pulse_ack();
        exp_vec(8'h23, "R7 vector for level 3");
        exp_int(1'b0, "R7 level 3 moved to service");
        wr(3'd4, 8'h0B);

        // R5 / R6 / R8
        raise(8'h22);
        exp_int(1'b1, "R5 two requests pending");
        pulse_ack();
        exp_vec(8'h21, "R5 level 1 beats level 5");
        exp_int(1'b0, "R6 level 5 blocked by level 1");
        raise(8'h01);
        exp_int(1'b1, "R6 level 0 nests over level 1");
        pulse_ack();
        exp_vec(8'h20, "R6 nested vector");
        wr(3'd4, 8'h08);
        exp_int(1'b0, "R8 specific clears only level 0");
        wr(3'd4, 8'h09);
        exp_int(1'b1, "R8 level 1 cleared releases 5");
        pulse_ack();
        exp_vec(8'h25, "R5 level 5 vector");
        wr(3'd4, 8'h0D);
        exp_int(1'b0, "R8 all cleared");

        // R9 non-specific
        raise(8'h40);
        pulse_ack();
        exp_vec(8'h26, "R7 level 6 vector");
        raise(8'h04);
        exp_int(1'b1, "R6 level 2 over level 6");
        pulse_ack();
        raise(8'h10);
        exp_int(1'b0, "R6 level 4 under level 2");
        wr(3'd4, 8'h00);
        exp_int(1'b1, "R9 non-specific cleared level 2");
        pulse_ack();
        exp_vec(8'h24, "R9 level 4 vector");
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h00);
        exp_int(1'b0, "R9 service empty");

        // R4 mask
        wr(3'd0, 8'h80);
        raise(8'h80);
        exp_int(1'b0, "R4 masked level 7 silent");
        pulse_ack();
        exp_vec(8'h24, "R7 ack without int ignored");
        wr(3'd0, 8'h00);
        exp_int(1'b1, "R4 unmask forwards latched request");
        pulse_ack();
        exp_vec(8'h27, "R4 level 7 vector");
        wr(3'd4, 8'h0F);

        // R3 level trigger
        wr(3'd3, 8'h04);
        @(negedge clk);
        irq_in[2] = 1'b1;
        tick(3);
        exp_int(1'b1, "R3 level request follows input");
        irq_in[2] = 1'b0;
        tick(3);
        exp_int(1'b0, "R3 level request dropped");
        irq_in[2] = 1'b1;
        tick(3);
        pulse_ack();
        exp_vec(8'h22, "R3 level 2 vector");
        exp_int(1'b0, "R3 in service blocks");
        wr(3'd4, 8'h00);
        exp_int(1'b1, "R3 still-high line re-requests");
        irq_in[2] = 1'b0;
        tick(3);
        exp_int(1'b0, "R3 line low clears request");
        wr(3'd3, 8'h00);

        // R10 auto end of service, R12 base low bits dropped
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h47);
        raise(8'h40);
        pulse_ack();
        exp_vec(8'h46, "R12 base low bits ignored");
        exp_int(1'b0, "R10 nothing pending");
        raise(8'h80);
        exp_int(1'b1, "R10 level 7 not blocked by 6");
        pulse_ack();
        exp_vec(8'h47, "R10 level 7 vector");

        // R11 rotation
        wr(3'd2, 8'h02);
        wr(3'd1, 8'h20);
        raise(8'h01);
        pulse_ack();
        exp_vec(8'h20, "R11 level 0 vector");
        wr(3'd4, 8'h08);
        raise(8'h21);
        pulse_ack();
        exp_vec(8'h25, "R11 level 5 beats rotated level 0");
        exp_int(1'b0, "R11 level 0 now least urgent");
        wr(3'd4, 8'h00);
        exp_int(1'b1, "R11 level 0 forwarded after clear");
        pulse_ack();
        exp_vec(8'h20, "R11 level 0 served");
        wr(3'd4, 8'h00);
        tick(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule